// File: doc/BRIEF.md
# I2C Host Interrupt Status and Vector Controller

This block keeps the event flags of an I2C host controller and decides when they reach the processor. Transfer logic pulses one-hot or multi-bit event strobes into it. Each strobe sets a sticky status flag. An enable mask gates those flags onto a single interrupt line. A small DMA configuration routes the receive-ready and transmit-ready flags onto two DMA request lines.

Software reaches the block through a simple register port with one read strobe, one write strobe and a 3-bit register select. The block has two variants, chosen by a revision parameter:

- Older variant (revision below 0x34). Status cannot be written. Flags are retired by reading a priority vector register, which returns the lowest pending enabled source and clears it.
- Newer variant. That vector register is absent. Status bits are retired by writing ones. A test register can force every flag high.

Register select codes: 0 status, 1 mask, 2 DMA configuration, 3 vector, 4 test.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A synchronous reset clears the status flags, the mask, the DMA configuration, the test register and all three request outputs.
- R2: Each set bit of `evtSet[5:0]` sets the matching status flag on the next clock edge. Flags stay set until they are cleared.
- R3: `irqOut` is registered and equals the OR of (status AND mask) as it stood one clock earlier.
- R4: The DMA configuration keeps only bits 15 and 7 of the written value. `rxDmaReq` is bit 15 AND status bit 3, and `txDmaReq` is bit 7 AND status bit 4. Both use the same one-clock lag as `irqOut`.
- R5: A DMA configuration write with bit 15 set clears mask bit 3. One with bit 7 set clears mask bit 4. No other mask bits change.
- R6: A mask write keeps bits 4:0 in the older variant and bits 5:0 in the newer one.
- R7: A status read returns the flags in bits 5:0 and the live `busBusy` input in bit 12. All other bits read as zero.
- R8: In the older variant, a vector read returns the 1-based index of the lowest set bit of (status AND mask), or 0 when there is none. The same read clears that one flag.
- R9: In the newer variant, a vector read returns 0 and leaves status unchanged.
- R10: In the newer variant, a status write clears the flags whose bits are set in (data AND 0x27). In the older variant, a status write has no effect.
- R11: The test register stores data AND 0xF80F and reads back that value. In the newer variant only, a test write with bit 11 set forces status bits 5:0 to one.
- R12: When an event sets a flag in the same cycle as a clear of that flag (by status write or vector read), the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | input | 1 | Read strobe; the register select picks the register |
| wrEn | input | 1 | Write strobe |
| regAddr | input | 3 | Register select: 0 status, 1 mask, 2 DMA, 3 vector, 4 test |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from the current state |
| evtSet | input | 6 | Event pulses from the transfer logic, one per status flag |
| busBusy | input | 1 | Live bus-busy indication |
| irqOut | output | 1 | Interrupt request, registered |
| rxDmaReq | output | 1 | Receive DMA request, registered |
| txDmaReq | output | 1 | Transmit DMA request, registered |

## Verification
Two cases can fall in the same cycle:

- An event pulse and a clear of the same flag. The bench provokes this in the newer variant by driving a write-one-to-clear status write together with an event on a cleared bit. In the older variant it drives a vector read together with an event on the lowest pending bit. In both cases it expects the flag to read back as set afterwards.
- A DMA configuration write and the mask clear it causes. The bench sweeps configuration values over a fully enabled mask and compares the mask and both request lines against a model.

Every 6-bit status pattern is also drained through the vector register. Each returned index and the resulting status are checked step by step.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  localparam int FLAG_W = 6;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 3'd0,
    SEL_MASK = 3'd1,
    SEL_DMA  = 3'd2,
    SEL_VEC  = 3'd3,
    SEL_TEST = 3'd4
  } regSel_t;

  typedef struct packed {
    logic    wrStat;
    logic    wrMask;
    logic    wrDma;
    logic    wrTest;
    logic    rdVec;
    regSel_t rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_vec_decode.sv
module irq_vec_decode
  import irqvec_pkg::*;
(
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regAddr,
  output strobe_t          stb
);
  regSel_t sel;
  assign sel = regSel_t'(regAddr);

  always_comb begin
    stb        = '0;
    stb.rdSel  = sel;
    stb.rdVec  = rdEn && (sel == SEL_VEC);
    if (wrEn) begin
      case (sel)
        SEL_STAT: stb.wrStat = 1'b1;
        SEL_MASK: stb.wrMask = 1'b1;
        SEL_DMA:  stb.wrDma  = 1'b1;
        SEL_TEST: stb.wrTest = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irqvec_pkg::*;
#(
  parameter logic [7:0] REVISION   = 8'h34,
  parameter logic [7:0] NEW_THRESH = 8'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [FLAG_W-1:0] evtSet,
  input  logic              busBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic [FLAG_W-1:0] statView,
  output logic [FLAG_W-1:0] maskView
);
  localparam bit              IS_NEW    = (REVISION >= NEW_THRESH);
  localparam logic [FLAG_W-1:0] MASK_KEEP = IS_NEW ? FLAG_W'(6'h3f) : FLAG_W'(6'h1f);
  localparam logic [FLAG_W-1:0] W1C_KEEP  = FLAG_W'(6'h27);
  localparam logic [DATA_W-1:0] TEST_KEEP = DATA_W'(16'hf80f);
  localparam int RX_BIT = 15;
  localparam int TX_BIT = 7;
  localparam int BUSY_BIT = 12;
  localparam int FORCE_BIT = 11;

  logic [FLAG_W-1:0] statQ, maskQ, statD, maskD;
  logic [FLAG_W-1:0] pend, lowBit, w1cClr, vecClr, forceSet;
  logic [DATA_W-1:0] vecIdx, testQ;
  logic              dmaRxQ, dmaTxQ;

  assign pend   = statQ & maskQ;
  assign lowBit = pend & (~pend + 1'b1);

  always_comb begin
    vecIdx = '0;
    for (int i = FLAG_W-1; i >= 0; i--) begin
      if (pend[i]) vecIdx = DATA_W'(i + 1);
    end
  end

  generate
    if (IS_NEW) begin : g_new
      assign w1cClr   = stb.wrStat ? (wrData[FLAG_W-1:0] & W1C_KEEP) : '0;
      assign vecClr   = '0;
      assign forceSet = (stb.wrTest && wrData[FORCE_BIT]) ? '1 : '0;
    end else begin : g_old
      assign w1cClr   = '0;
      assign vecClr   = stb.rdVec ? lowBit : '0;
      assign forceSet = '0;
    end
  endgenerate

  // events are applied after clears, so a coincident set survives
  assign statD = (statQ & ~(w1cClr | vecClr)) | evtSet | forceSet;

  always_comb begin
    maskD = maskQ;
    if (stb.wrMask) maskD = wrData[FLAG_W-1:0] & MASK_KEEP;
    if (stb.wrDma) begin
      if (wrData[RX_BIT]) maskD[3] = 1'b0;
      if (wrData[TX_BIT]) maskD[4] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statQ    <= '0;
      maskQ    <= '0;
      dmaRxQ   <= 1'b0;
      dmaTxQ   <= 1'b0;
      testQ    <= '0;
      irqOut   <= 1'b0;
      rxDmaReq <= 1'b0;
      txDmaReq <= 1'b0;
    end else begin
      statQ    <= statD;
      maskQ    <= maskD;
      if (stb.wrDma) begin
        dmaRxQ <= wrData[RX_BIT];
        dmaTxQ <= wrData[TX_BIT];
      end
      if (stb.wrTest) testQ <= wrData & TEST_KEEP;
      irqOut   <= |pend;
      rxDmaReq <= dmaRxQ & statQ[3];
      txDmaReq <= dmaTxQ & statQ[4];
    end
  end

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      SEL_STAT: begin
        rdData[FLAG_W-1:0] = statQ;
        rdData[BUSY_BIT]   = busBusy;
      end
      SEL_MASK: rdData[FLAG_W-1:0] = maskQ;
      SEL_DMA: begin
        rdData[RX_BIT] = dmaRxQ;
        rdData[TX_BIT] = dmaTxQ;
      end
      SEL_VEC:  rdData = IS_NEW ? '0 : vecIdx;
      SEL_TEST: rdData = testQ;
      default:  rdData = '0;
    endcase
  end

  assign statView = statQ;
  assign maskView = maskQ;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqvec_pkg::*;
#(
  parameter logic [7:0] REVISION   = 8'h34,
  parameter logic [7:0] NEW_THRESH = 8'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [FLAG_W-1:0] evtSet,
  input  logic              busBusy,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  strobe_t           stb;
  logic [FLAG_W-1:0] statView, maskView;

  irq_vec_decode uDec (
    .rdEn(rdEn), .wrEn(wrEn), .regAddr(regAddr), .stb(stb)
  );

  irq_vec_datapath #(.REVISION(REVISION), .NEW_THRESH(NEW_THRESH)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .evtSet(evtSet),
    .busBusy(busBusy), .rdData(rdData), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .statView(statView), .maskView(maskView)
  );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irqvec_pkg::*;
#(
  parameter logic [7:0] REVISION   = 8'h34,
  parameter logic [7:0] NEW_THRESH = 8'h34
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic              wrEn,
  input logic [SEL_W-1:0]  regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [FLAG_W-1:0] evtSet,
  input logic              irqOut,
  input logic [FLAG_W-1:0] statView,
  input logic [FLAG_W-1:0] maskView
);
  localparam bit IS_NEW = (REVISION >= NEW_THRESH);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irqOut == $past(|(statView & maskView))));

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (|evtSet)) |=> ((statView & $past(evtSet)) == $past(evtSet)));

  // R5
  dma_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && wrEn && regAddr == 3'd2 && wrData[15]) |=> !maskView[3]);

  // R6
  mask_width_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !IS_NEW) |-> !maskView[5]);

  // R8
  vec_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !IS_NEW && rdEn && regAddr == 3'd3 && evtSet == '0 &&
     (statView & maskView) != '0)
    |=> ($countones(statView) == $countones($past(statView)) - 1));

  // R10
  old_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !IS_NEW && wrEn && regAddr == 3'd0 && evtSet == '0)
    |=> (statView == $past(statView)));
endmodule

bind irq_vec_ctrl irq_vec_chk #(.REVISION(REVISION), .NEW_THRESH(NEW_THRESH)) uChk (
  .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .regAddr(regAddr),
  .wrData(wrData), .evtSet(evtSet), .irqOut(irqOut),
  .statView(statView), .maskView(maskView)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdEn = 1'b0, wrEn = 1'b0, busBusy = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [5:0]  evtSet = '0;
  logic [15:0] rdOld, rdNew;
  logic        irq0, irq1, rx0, rx1, tx0, tx1;

  int total = 0;
  int bad = 0;

  // model state, index 0 = older variant, 1 = newer variant
  logic [5:0]  mStat [2];
  logic [5:0]  mMask [2];
  logic        mRx [2];
  logic        mTx [2];
  logic [15:0] mTest [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl #(.REVISION(8'h20)) u0 (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdOld), .evtSet(evtSet), .busBusy(busBusy),
    .irqOut(irq0), .rxDmaReq(rx0), .txDmaReq(tx0));

  irq_vec_ctrl #(.REVISION(8'h34)) u1 (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdNew), .evtSet(evtSet), .busBusy(busBusy),
    .irqOut(irq1), .rxDmaReq(rx1), .txDmaReq(tx1));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] lowestOf(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 6'(1 << i);
    return 6'd0;
  endfunction

  function automatic logic [15:0] vecOf(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  function automatic logic [15:0] expRead(input int k, input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, busBusy, 6'b0, mStat[k]};
      3'd1: return {10'b0, mMask[k]};
      3'd2: return {mRx[k], 7'b0, mTx[k], 7'b0};
      3'd3: return (k == 1) ? 16'd0 : vecOf(mStat[k] & mMask[k]);
      3'd4: return mTest[k];
      default: return 16'd0;
    endcase
  endfunction

  task automatic applyModel(input int k, input logic rd, input logic wr,
                            input logic [2:0] a, input logic [15:0] d, input logic [5:0] ev);
    logic [5:0] clr, frc;
    clr = '0; frc = '0;
    if (k == 1 && wr && a == 3'd0) clr = d[5:0] & 6'h27;
    if (k == 0 && rd && a == 3'd3) clr = lowestOf(mStat[k] & mMask[k]);
    if (k == 1 && wr && a == 3'd4 && d[11]) frc = 6'h3f;
    if (wr && a == 3'd1) mMask[k] = d[5:0] & ((k == 1) ? 6'h3f : 6'h1f);
    if (wr && a == 3'd2) begin
      mRx[k] = d[15]; mTx[k] = d[7];
      if (d[15]) mMask[k][3] = 1'b0;
      if (d[7])  mMask[k][4] = 1'b0;
    end
    if (wr && a == 3'd4) mTest[k] = d & 16'hf80f;
    mStat[k] = (mStat[k] & ~clr) | ev | frc;
  endtask

  // one bus cycle; checks read data (before the edge) when rd is set
  task automatic cycle(input string req, input logic rd, input logic wr,
                       input logic [2:0] a, input logic [15:0] d, input logic [5:0] ev);
    @(negedge clk);
    rdEn = rd; wrEn = wr; regAddr = a; wrData = d; evtSet = ev;
    #1;
    if (rd) begin
      chk(req, rdOld, expRead(0, a));
      chk(req, rdNew, expRead(1, a));
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) applyModel(k, rd, wr, a, d, ev);
    @(negedge clk);
    rdEn = 0; wrEn = 0; evtSet = '0;
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 5; a++) begin
      if (a != 3) cycle(req, 1, 0, 3'(a), 16'h0, 6'h0);
    end
  endtask

  // outputs lag state by one edge: one idle cycle, then compare
  task automatic chkOut(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, {13'b0, irq0, rx0, tx0},
        {13'b0, |(mStat[0] & mMask[0]), mRx[0] & mStat[0][3], mTx[0] & mStat[0][4]});
    chk(req, {13'b0, irq1, rx1, tx1},
        {13'b0, |(mStat[1] & mMask[1]), mRx[1] & mStat[1][3], mTx[1] & mStat[1][4]});
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int k = 0; k < 2; k++) begin
      mStat[k] = '0; mMask[k] = '0; mRx[k] = 0; mTx[k] = 0; mTest[k] = '0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state of registers and outputs
    readAll("R1 reset");
    chkOut("R1 reset outputs");

    // R2: each event bit sets its flag, flags accumulate
    for (int i = 0; i < 6; i++) begin
      cycle("R2 event", 0, 0, 3'd0, 16'h0, 6'(1 << i));
      cycle("R2 event read", 1, 0, 3'd0, 16'h0, 6'h0);
    end

    // R6, R3: mask sweep with all flags set
    for (int v = 0; v < 64; v++) begin
      cycle("R6 mask write", 0, 1, 3'd1, 16'(v) | 16'hffc0, 6'h0);
      cycle("R6 mask read", 1, 0, 3'd1, 16'h0, 6'h0);
      chkOut("R3 irq");
    end

    // R4, R5: DMA configuration against a full mask
    for (int j = 0; j < 5; j++) begin
      logic [15:0] dv;
      dv = (j == 0) ? 16'h0000 : (j == 1) ? 16'h0080 : (j == 2) ? 16'h8000 :
           (j == 3) ? 16'h8080 : 16'hffff;
      doReset();
      cycle("R4 flags", 0, 0, 3'd0, 16'h0, (j == 2) ? 6'h08 : 6'h18);
      cycle("R5 mask", 0, 1, 3'd1, 16'h003f, 6'h0);
      cycle("R4 dma write", 0, 1, 3'd2, dv, 6'h0);
      cycle("R4 dma read", 1, 0, 3'd2, 16'h0, 6'h0);
      cycle("R5 mask read", 1, 0, 3'd1, 16'h0, 6'h0);
      chkOut("R4 dma outputs");
    end

    // R7: live busy bit
    busBusy = 1;
    cycle("R7 busy", 1, 0, 3'd0, 16'h0, 6'h0);
    busBusy = 0;
    cycle("R7 idle", 1, 0, 3'd0, 16'h0, 6'h0);

    // R8, R9: drain every pattern through the vector register
    for (int s = 0; s < 64; s++) begin
      doReset();
      cycle("R8 set", 0, 0, 3'd0, 16'h0, 6'(s));
      cycle("R8 mask", 0, 1, 3'd1, 16'h003f, 6'h0);
      for (int n = 0; n < 7; n++) cycle("R8 R9 vector", 1, 0, 3'd3, 16'h0, 6'h0);
      cycle("R9 status after", 1, 0, 3'd0, 16'h0, 6'h0);
    end

    // R11: test register keep mask and force
    doReset();
    cycle("R11 test write", 0, 1, 3'd4, 16'hffff, 6'h0);
    cycle("R11 test read", 1, 0, 3'd4, 16'h0, 6'h0);
    cycle("R11 forced status", 1, 0, 3'd0, 16'h0, 6'h0);

    // R10: write-one-to-clear limited to 0x27, older ignores
    cycle("R10 w1c", 0, 1, 3'd0, 16'hffff, 6'h0);
    cycle("R10 status", 1, 0, 3'd0, 16'h0, 6'h0);
    cycle("R10 old write", 0, 1, 3'd0, 16'h0001, 6'h0);
    cycle("R10 status2", 1, 0, 3'd0, 16'h0, 6'h0);

    // R12: coincident event and clear
    doReset();
    cycle("R12 set", 0, 0, 3'd0, 16'h0, 6'h3f);
    cycle("R12 mask", 0, 1, 3'd1, 16'h003f, 6'h0);
    cycle("R12 w1c plus event", 0, 1, 3'd0, 16'h0027, 6'h01);
    cycle("R12 vector plus event", 1, 0, 3'd3, 16'h0, 6'h01);
    cycle("R12 status", 1, 0, 3'd0, 16'h0, 6'h0);
    chk("R12 new bit0 kept", rdNew & 16'h1, 16'h1);
    chkOut("R12 outputs");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule